// File: doc/BRIEF.md
# Refresh Scheduler with Posting Credit

This block decides when a synchronous DRAM needs an auto-refresh. A free-running interval timer marks each average refresh period. Every time the timer wraps, the block adds one to a debt counter that records refreshes owed. The memory controller can serve that debt at once, or it can defer refreshes while traffic is heavy. Each refresh it issues pays back one unit.

Deferral is bounded. The debt never exceeds a configured ceiling (eight by default), so the longest gap between refreshes is eight average intervals. When the ceiling is reached, the block raises an urgent request. If the device is in power down at that moment, the block also asks the controller to leave power down, because no refresh can run there.

After a refresh the block holds a busy flag for the refresh cycle time. The controller must issue no refresh or activate while that flag is set. Bank closing and command arbitration belong to the controller. All interval lengths are parameters counted in clock cycles.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, all four outputs are low and the debt is zero.
- R2: The debt increases by one at the end of every INTERVAL_CYC clock cycles, counted from reset release. The first increase makes `rf_req` rise exactly INTERVAL_CYC cycles after release.
- R3: `rf_req` is high exactly when the debt is one or more.
- R4: A grant is accepted when `rf_grant` is high, `banks_idle` is high, the debt is non-zero and `rf_busy` is low. An accepted grant lowers the debt by one at the next clock edge.
- R5: A grant that arrives while the debt is zero, while `rf_busy` is high, or while `banks_idle` is low has no effect on the debt or on `rf_busy`.
- R6: After an accepted grant, `rf_busy` is high for exactly RFC_CYC consecutive cycles, starting the cycle after the grant.
- R7: `rf_urgent` is high exactly when the debt equals MAX_DEBT.
- R8: The debt never exceeds MAX_DEBT. An interval that ends while the debt is at MAX_DEBT, with no grant in the same cycle, leaves the debt unchanged.
- R9: `pd_exit_req` is high exactly when `pd_active` is high and the debt equals MAX_DEBT.
- R10: If an accepted grant and an interval end fall in the same cycle, the debt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when every bank is precharged |
| rf_grant | input | 1 | One-cycle strobe: the controller issues a refresh now |
| pd_active | input | 1 | High while the device is in power down |
| rf_req | output | 1 | At least one refresh is owed |
| rf_urgent | output | 1 | Debt has reached the ceiling |
| pd_exit_req | output | 1 | Leave power down so the owed refresh can run |
| rf_busy | output | 1 | Refresh cycle time still running; no refresh or activate allowed |

## Verification
A wrong debt value shows up at the ports in one of two ways. It appears within one cycle as a mismatch on `rf_req` or `rf_urgent`, when the count crosses zero or the ceiling. Otherwise it stays hidden until the next crossing, so the stimulus drives the debt all the way up to the ceiling and back down to zero. A phase error in the interval timer moves the rising edge of `rf_req` away from its expected cycle. A wrong busy count changes the length of `rf_busy` and which later grants are accepted. The bench therefore covers both the mixed cases, an interval end in the same cycle as a grant and grants during busy, and grants while banks are open.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   // Width of a counter that must hold values 0 .. n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int unsigned INTERVAL_CYC = 975
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire
);
   localparam int unsigned CW = rfsh_pkg::cnt_width(INTERVAL_CYC);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

   logic [CW-1:0] cnt;

   assign expire = (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (expire) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   // R2: the counter never goes beyond its terminal value
   assert_period_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
   parameter int unsigned MAX_DEBT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic owed,
   output logic full
);
   localparam int unsigned DW = rfsh_pkg::cnt_width(MAX_DEBT + 1);
   localparam logic [DW-1:0] CEIL = DW'(MAX_DEBT);

   logic [DW-1:0] debt;

   assign owed = (debt != '0);
   assign full = (debt == CEIL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (!full) debt <= debt + 1'b1;
            2'b01:   debt <= debt - 1'b1;
            default: debt <= debt;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= CEIL);
   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && !full) |=> (debt == $past(debt) + 1'b1));
   assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> (debt == $past(debt) - 1'b1));
   assert_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(debt));
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> owed);
endmodule

// File: rtl/rfsh_rfc_timer.sv
module rfsh_rfc_timer #(
   parameter int unsigned RFC_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (RFC_CYC == 0) begin : g_no_hold
         assign busy = 1'b0;
      end else begin : g_hold
         localparam int unsigned TW = rfsh_pkg::cnt_width(RFC_CYC + 1);
         logic [TW-1:0] left;

         assign busy = (left != '0);

         always_ff @(posedge clk) begin
            if (!rst_n)     left <= '0;
            else if (start) left <= TW'(RFC_CYC);
            else if (busy)  left <= left - 1'b1;
         end

         assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
         assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> !busy);
      end
   endgenerate
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
   parameter int unsigned INTERVAL_CYC = 975,
   parameter int unsigned RFC_CYC      = 16,
   parameter int unsigned MAX_DEBT     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic banks_idle,
   input  logic rf_grant,
   input  logic pd_active,
   output logic rf_req,
   output logic rf_urgent,
   output logic pd_exit_req,
   output logic rf_busy
);
   initial begin
      assert_param_interval: assert (INTERVAL_CYC >= 2)
         else $error("INTERVAL_CYC must be at least 2");
      assert_param_rfc: assert (RFC_CYC < INTERVAL_CYC)
         else $error("RFC_CYC must be shorter than INTERVAL_CYC");
      assert_param_debt: assert (MAX_DEBT >= 1)
         else $error("MAX_DEBT must be at least 1");
   end

   logic tick;
   logic owed;
   logic full;
   logic accept;

   rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .expire(tick));

   rfsh_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
      .clk(clk), .rst_n(rst_n), .inc(tick), .dec(accept),
      .owed(owed), .full(full));

   rfsh_rfc_timer #(.RFC_CYC(RFC_CYC)) u_rfc (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(rf_busy));

   assign accept      = rf_grant && banks_idle && owed && !rf_busy;
   assign rf_req      = owed;
   assign rf_urgent   = full;
   assign pd_exit_req = pd_active && full;

   assert_urgent_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_urgent |-> rf_req);
   assert_pdx_urgent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit_req |-> (rf_urgent && pd_active));
   assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_grant && rf_busy && !tick) |=> $stable(rf_req));
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!rf_req && !rf_busy));
endmodule

// File: tb/tb_rfsh_sched.sv
`timescale 1ns/1ps
module tb_rfsh_sched;
   localparam int unsigned INT  = 20;
   localparam int unsigned RFC  = 5;
   localparam int unsigned MAXD = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic banks_idle, rf_grant, pd_active;
   logic rf_req, rf_urgent, pd_exit_req, rf_busy;

   always #4 clk = ~clk;   // 125 MHz

   rfsh_sched #(.INTERVAL_CYC(INT), .RFC_CYC(RFC), .MAX_DEBT(MAXD)) dut (
      .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .rf_grant(rf_grant),
      .pd_active(pd_active), .rf_req(rf_req), .rf_urgent(rf_urgent),
      .pd_exit_req(pd_exit_req), .rf_busy(rf_busy));

   typedef struct {
      logic  req;
      logic  urg;
      logic  pdx;
      logic  busy;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Model state, derived from the requirements
   int m_ic = 0, m_debt = 0, m_busy = 0;

   task automatic cmp(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and push the expected outputs after the edge
   task automatic step(input logic g, input logic idle, input logic pd, input string tag);
      bit ex, acc;
      exp_t e;
      rf_grant = g; banks_idle = idle; pd_active = pd;
      ex  = (m_ic == INT - 1);
      acc = g && idle && (m_debt > 0) && (m_busy == 0);
      if (ex && !acc && m_debt < MAXD) m_debt++;            // R2, R8
      else if (acc && !ex) m_debt--;                        // R4; both -> unchanged R10
      m_ic   = ex ? 0 : m_ic + 1;
      m_busy = acc ? RFC : ((m_busy > 0) ? m_busy - 1 : 0);  // R6
      e.req  = (m_debt != 0);                               // R3
      e.urg  = (m_debt == MAXD);                            // R7
      e.pdx  = pd && (m_debt == MAXD);                      // R9
      e.busy = (m_busy != 0);
      e.tag  = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compare away from the active edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         cmp(e.tag, "rf_req(R3)",      rf_req,      e.req);
         cmp(e.tag, "rf_urgent(R7)",   rf_urgent,   e.urg);
         cmp(e.tag, "pd_exit_req(R9)", pd_exit_req, e.pdx);
         cmp(e.tag, "rf_busy(R6)",     rf_busy,     e.busy);
      end
   end

   initial begin
      rst_n = 1'b0; banks_idle = 1'b0; rf_grant = 1'b0; pd_active = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      cmp("R1", "rf_req", rf_req, 1'b0);
      cmp("R1", "rf_urgent", rf_urgent, 1'b0);
      cmp("R1", "pd_exit_req", pd_exit_req, 1'b0);
      cmp("R1", "rf_busy", rf_busy, 1'b0);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 1'b0, "R1");
      // R2: first request after INTERVAL_CYC cycles
      for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b0, "R2");
      // R5: grant with banks open is ignored
      for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, "R5");
      // R4: accepted grant
      step(1'b1, 1'b1, 1'b0, "R4");
      // R5: grants during busy and at zero debt are ignored
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R5");
      // R10: grant in the same cycle as an interval end
      for (int i = 0; i < 45; i++) step(1'b0, 1'b1, 1'b0, "R2");
      while (!(m_ic == INT - 1 && m_busy == 0 && m_debt > 0)) step(1'b0, 1'b1, 1'b0, "R10");
      step(1'b1, 1'b1, 1'b0, "R10");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R10");
      // R7, R8, R9: saturate in power down
      for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 1'b1, "R8");
      step(1'b0, 1'b0, 1'b0, "R9");
      // R4, R6: drain the full debt
      for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 1'b0, "R4");
      rf_grant = 1'b0;
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule